// File: doc/BRIEF.md
# Text Hex Record Stream Parser

This block turns a stream of ASCII characters, one per valid cycle, into byte writes for a memory. The text is a series of lines, and each line is one record.

A record starts with a prefix character that sets how wide its address field is. Next come a two-digit byte count, a starting address and then that many data bytes, each written as two hex digits. Spaces may sit between tokens. No checksum is carried.

For each data byte the parser raises a one-cycle write strobe. The strobe carries the byte value and the address, which is the record's starting address plus the byte's position in the record.

A record that ends with exactly the declared number of bytes gives a one-cycle done pulse. A malformed line gives a one-cycle error pulse. After an error, the rest of the line is thrown away.

Top module: `hexrec_parser`

## Requirements
- R1: The first non-space character of a line selects the address field. 0x2D ('-') selects 4 hex digits (16 bits), 0x3D ('=') selects 6 digits (24 bits) and 0x2B ('+') selects 8 digits (32 bits). The address is zero-extended to the 32-bit `wr_addr`.
- R2: After the prefix, the record holds a byte count of exactly two hex digits, then the address, then the data bytes, each of two hex digits. Spaces (0x20) between tokens are skipped. A space inside a token is a format error.
- R3: Each data byte raises `wr_en` for exactly one cycle, in the cycle after the byte's second digit is accepted. The first digit is the high nibble of `wr_data`. `wr_addr` is the starting address plus the byte index (0 for the first byte), added modulo 2^32.
- R4: The digits 0-9, A-F and a-f are all accepted as hex digits and give the same values in either case.
- R5: Any other character inside a record raises `err` for one cycle, in the cycle after that character. It makes the parser discard input up to and including the next line feed (0x0A). No write occurs while input is being discarded.
- R6: A carriage return (0x0D) or a line feed ends a record. If exactly N bytes arrived, `rec_done` pulses for one cycle in the next cycle. N = 0 is a legal record.
- R7: If the line ends before the header is complete, with fewer than N bytes, or with half a byte, `err` pulses instead of `rec_done`. Bytes that were already complete remain written.
- R8: A data digit that arrives after N bytes have been received raises `err`. That byte is not written, and the rest of the line is discarded.
- R9: Blank lines, repeated CR/LF characters and spaces before a prefix produce no write, no `err` and no `rec_done`.
- R10: A synchronous reset clears all outputs and abandons any partly received record. The parser then waits for a prefix.
- R11: Cycles with `in_valid` low change no state. In the following cycle, `wr_en`, `rec_done` and `err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | `in_char` holds a character this cycle |
| in_char | input | 8 | ASCII character |
| wr_en | output | 1 | One-cycle write strobe |
| wr_addr | output | 32 | Write address (base plus byte index) |
| wr_data | output | 8 | Write byte |
| rec_done | output | 1 | One-cycle pulse: record ended cleanly |
| err | output | 1 | One-cycle pulse: format error |

## Verification
The bench targets the boundaries of the byte count.

- A zero-length record must complete without writing anything.
- A short line must flag an error without raising done.
- A surplus byte must be refused rather than written. A parser that compared the count off by one would write that byte or report the short line as clean.

It also checks each address width, including a 32-bit address that wraps past all ones.

It checks that the first strobe comes in the cycle after the second digit of the first byte. An extra pipeline stage would show up there as a shifted position.

Finally it covers bad characters followed by a good record, CR-LF pairs, gaps in `in_valid`, and a reset in the middle of a record. A parser that failed to resynchronise on the line feed, or that kept stale state across reset, would lose or corrupt the record that follows.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;

  localparam logic [7:0] CH_SPACE = 8'h20;
  localparam logic [7:0] CH_LF    = 8'h0A;
  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_P16   = 8'h2D;
  localparam logic [7:0] CH_P24   = 8'h3D;
  localparam logic [7:0] CH_P32   = 8'h2B;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COUNT,
    ST_ADDR,
    ST_DATA,
    ST_DROP
  } pstate_t;

  typedef enum logic [2:0] {
    CC_HEX,
    CC_SPACE,
    CC_CR,
    CC_LF,
    CC_P16,
    CC_P24,
    CC_P32,
    CC_BAD
  } cclass_t;

  function automatic logic is_hex(input logic [7:0] c);
    return (c >= 8'h30 && c <= 8'h39) ||
           (c >= 8'h41 && c <= 8'h46) ||
           (c >= 8'h61 && c <= 8'h66);
  endfunction

  // Letters share their low nibble across case: 'A'/'a' -> 1, plus 9 = 10.
  function automatic logic [3:0] hex_nibble(input logic [7:0] c);
    if (c <= 8'h39) return c[3:0];
    return c[3:0] + 4'd9;
  endfunction

  function automatic cclass_t classify(input logic [7:0] c);
    if (is_hex(c))      return CC_HEX;
    if (c == CH_SPACE)  return CC_SPACE;
    if (c == CH_CR)     return CC_CR;
    if (c == CH_LF)     return CC_LF;
    if (c == CH_P16)    return CC_P16;
    if (c == CH_P24)    return CC_P24;
    if (c == CH_P32)    return CC_P32;
    return CC_BAD;
  endfunction

  function automatic logic [3:0] addr_digits(input cclass_t p);
    case (p)
      CC_P16:  return 4'd4;
      CC_P24:  return 4'd6;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/hexrec_classify.sv
module hexrec_classify
  import hexrec_pkg::*;
(
  input  logic [7:0] ch,
  output cclass_t    cls,
  output logic [3:0] nib
);
  always_comb begin
    cls = classify(ch);
    nib = hex_nibble(ch);
  end
endmodule

// File: rtl/hexrec_addr.sv
module hexrec_addr #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              shift,
  input  logic [3:0]        nib,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr_nxt
);
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      base_q <= '0;
      idx_q  <= '0;
    end else begin
      if (shift) base_q <= {base_q[ADDR_W-5:0], nib};
      if (inc)   idx_q  <= idx_q + 1'b1;
    end
  end

  assign addr_nxt = base_q + ADDR_W'(idx_q);
endmodule

// File: rtl/hexrec_ctrl.sv
module hexrec_ctrl
  import hexrec_pkg::*;
#(
  parameter int COUNT_DIGITS    = 2,
  parameter int MAX_ADDR_DIGITS = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       valid,
  input  cclass_t    cls,
  input  logic [3:0] nib,
  output pstate_t    state,
  output logic       ev_write,
  output logic       ev_done,
  output logic       ev_err,
  output logic       base_clr,
  output logic       base_shift,
  output logic [7:0] byte_val
);
  localparam int CNT_W = 4 * COUNT_DIGITS;
  localparam int DIG_W = $clog2(MAX_ADDR_DIGITS + 1);

  pstate_t          state_q, state_d;
  logic [DIG_W-1:0] ndig_q, ndig_d;
  logic [3:0]       adig_q, adig_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic [CNT_W-1:0] got_q, got_d;
  logic [3:0]       hi_q, hi_d;

  assign state    = state_q;
  assign byte_val = {hi_q, nib};

  always_comb begin
    state_d    = state_q;
    ndig_d     = ndig_q;
    adig_d     = adig_q;
    count_d    = count_q;
    got_d      = got_q;
    hi_d       = hi_q;
    ev_write   = 1'b0;
    ev_done    = 1'b0;
    ev_err     = 1'b0;
    base_clr   = 1'b0;
    base_shift = 1'b0;
    if (valid) begin
      case (state_q)
        ST_IDLE: begin
          case (cls)
            CC_P16, CC_P24, CC_P32: begin
              state_d  = ST_COUNT;
              adig_d   = addr_digits(cls);
              ndig_d   = '0;
              count_d  = '0;
              got_d    = '0;
              base_clr = 1'b1;
            end
            CC_SPACE, CC_CR, CC_LF: ;
            default: begin
              ev_err  = 1'b1;
              state_d = ST_DROP;
            end
          endcase
        end
        ST_DROP: begin
          if (cls == CC_LF) state_d = ST_IDLE;
        end
        ST_COUNT: begin
          case (cls)
            CC_HEX: begin
              count_d = {count_q[CNT_W-5:0], nib};
              if (ndig_q == DIG_W'(COUNT_DIGITS - 1)) begin
                ndig_d  = '0;
                state_d = ST_ADDR;
              end else begin
                ndig_d = ndig_q + 1'b1;
              end
            end
            CC_SPACE: begin
              if (ndig_q != '0) begin
                ev_err  = 1'b1;
                state_d = ST_DROP;
              end
            end
            CC_CR, CC_LF: begin
              ev_err  = 1'b1;
              state_d = ST_IDLE;
            end
            default: begin
              ev_err  = 1'b1;
              state_d = ST_DROP;
            end
          endcase
        end
        ST_ADDR: begin
          case (cls)
            CC_HEX: begin
              base_shift = 1'b1;
              if (ndig_q == DIG_W'(adig_q - 4'd1)) begin
                ndig_d  = '0;
                state_d = ST_DATA;
              end else begin
                ndig_d = ndig_q + 1'b1;
              end
            end
            CC_SPACE: begin
              if (ndig_q != '0) begin
                ev_err  = 1'b1;
                state_d = ST_DROP;
              end
            end
            CC_CR, CC_LF: begin
              ev_err  = 1'b1;
              state_d = ST_IDLE;
            end
            default: begin
              ev_err  = 1'b1;
              state_d = ST_DROP;
            end
          endcase
        end
        ST_DATA: begin
          case (cls)
            CC_HEX: begin
              if (ndig_q == '0) begin
                if (got_q == count_q) begin
                  ev_err  = 1'b1;
                  state_d = ST_DROP;
                end else begin
                  hi_d   = nib;
                  ndig_d = DIG_W'(1);
                end
              end else begin
                ev_write = 1'b1;
                ndig_d   = '0;
                got_d    = got_q + 1'b1;
              end
            end
            CC_SPACE: begin
              if (ndig_q != '0) begin
                ev_err  = 1'b1;
                state_d = ST_DROP;
              end
            end
            CC_CR, CC_LF: begin
              if (ndig_q != '0 || got_q != count_q) ev_err = 1'b1;
              else ev_done = 1'b1;
              state_d = ST_IDLE;
            end
            default: begin
              ev_err  = 1'b1;
              state_d = ST_DROP;
            end
          endcase
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ndig_q  <= '0;
      adig_q  <= 4'd4;
      count_q <= '0;
      got_q   <= '0;
      hi_q    <= '0;
    end else begin
      state_q <= state_d;
      ndig_q  <= ndig_d;
      adig_q  <= adig_d;
      count_q <= count_d;
      got_q   <= got_d;
      hi_q    <= hi_d;
    end
  end
endmodule

// File: rtl/hexrec_parser.sv
module hexrec_parser
  import hexrec_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int COUNT_DIGITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_char,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              rec_done,
  output logic              err
);
  localparam int MAX_ADDR_DIGITS = ADDR_W / 4;
  localparam int IDX_W           = 4 * COUNT_DIGITS;

  cclass_t           cls;
  logic [3:0]        nib;
  pstate_t           state;
  logic              ev_write, ev_done, ev_err;
  logic              base_clr, base_shift;
  logic [7:0]        byte_val;
  logic [ADDR_W-1:0] addr_nxt;

  hexrec_classify i_classify (
    .ch  (in_char),
    .cls (cls),
    .nib (nib)
  );

  hexrec_ctrl #(
    .COUNT_DIGITS    (COUNT_DIGITS),
    .MAX_ADDR_DIGITS (MAX_ADDR_DIGITS)
  ) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .valid      (in_valid),
    .cls        (cls),
    .nib        (nib),
    .state      (state),
    .ev_write   (ev_write),
    .ev_done    (ev_done),
    .ev_err     (ev_err),
    .base_clr   (base_clr),
    .base_shift (base_shift),
    .byte_val   (byte_val)
  );

  hexrec_addr #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
  ) i_addr (
    .clk      (clk),
    .rst      (rst),
    .clr      (base_clr),
    .shift    (base_shift),
    .nib      (nib),
    .inc      (ev_write),
    .addr_nxt (addr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      rec_done <= 1'b0;
      err      <= 1'b0;
    end else begin
      wr_en    <= ev_write;
      rec_done <= ev_done;
      err      <= ev_err;
      if (ev_write) begin
        wr_addr <= addr_nxt;
        wr_data <= byte_val;
      end
    end
  end
endmodule

// File: rtl/hexrec_parser_chk.sv
module hexrec_parser_chk
  import hexrec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [7:0]        in_char,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              rec_done,
  input logic              err,
  input pstate_t           state
);
  logic              in_rec;
  logic [ADDR_W-1:0] prev_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_rec    <= 1'b0;
      prev_addr <= '0;
    end else if (rec_done || err) begin
      in_rec <= 1'b0;
    end else if (wr_en) begin
      in_rec    <= 1'b1;
      prev_addr <= wr_addr;
    end
  end

  // R10: reset silences all pulses
  a_r10_reset_quiet: assert property (@(posedge clk)
    rst |=> (!wr_en && !rec_done && !err));

  // R11: an idle input cycle produces no pulse
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> (!wr_en && !rec_done && !err));

  // R3: strobe lasts one cycle
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R3: consecutive bytes of a record go to consecutive addresses
  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    (wr_en && in_rec) |-> (wr_addr == prev_addr + 1'b1));

  // R6: done only follows an end-of-line character
  a_r6_done_after_eol: assert property (@(posedge clk) disable iff (rst)
    rec_done |-> ($past(in_valid) &&
                  ($past(in_char) == CH_LF || $past(in_char) == CH_CR)));

  // R5: error never coincides with a write or a done
  a_r5_err_alone: assert property (@(posedge clk) disable iff (rst)
    err |-> (!wr_en && !rec_done));

  // R5: no write leaves the discard state
  a_r5_drop_no_write: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_DROP) |-> !wr_en);
endmodule

bind hexrec_parser hexrec_parser_chk #(.ADDR_W(ADDR_W)) i_hexrec_parser_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_char  (in_char),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .rec_done (rec_done),
  .err      (err),
  .state    (state)
);

// File: tb/test_hexrec_parser.sv
`timescale 1ns/1ps
module test_hexrec_parser;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_char = 8'h00;
  logic        wr_en, rec_done, err;
  logic [31:0] wr_addr;
  logic [7:0]  wr_data;

  hexrec_parser i_hexrec_parser (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_char(in_char),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rec_done(rec_done), .err(err)
  );

  always #2.5 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int nwr, nerr, ndone, cpos, idle_hits;
  logic [31:0] wa [64];
  logic [7:0]  wd [64];
  int          wp [64];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    check(act == exp, req, what, act, exp);
  endtask

  task automatic clear_log();
    nwr = 0; nerr = 0; ndone = 0; cpos = 0; idle_hits = 0;
  endtask

  task automatic observe();
    if (wr_en) begin
      if (nwr < 64) begin
        wa[nwr] = wr_addr; wd[nwr] = wr_data; wp[nwr] = cpos;
      end
      nwr++;
    end
    if (err) nerr++;
    if (rec_done) ndone++;
  endtask

  task automatic send_char(input logic [7:0] c);
    in_valid = 1'b1;
    in_char  = c;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    observe();
    cpos++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (wr_en || err || rec_done) idle_hits++;
    end
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_char(s[i]);
  endtask

  task automatic expect_counts(input string req, input int w, input int d, input int e);
    chk_eq(req, "write count", nwr, w);
    chk_eq(req, "done count", ndone, d);
    chk_eq(req, "error count", nerr, e);
  endtask

  task automatic t_reset_state();
    chk_eq("R10", "outputs after reset", {29'b0, wr_en, rec_done, err}, 32'h0);
    chk_eq("R10", "wr_addr after reset", wr_addr, 32'h0);
  endtask

  task automatic t_rec16();
    clear_log();
    send_str("-03 1234 AB cd 0F\n");
    expect_counts("R1", 3, 1, 0);
    chk_eq("R1", "addr0", wa[0], 32'h0000_1234);
    chk_eq("R3", "data0", wd[0], 8'hAB);
    chk_eq("R4", "data1 lowercase", wd[1], 8'hCD);
    chk_eq("R3", "addr2", wa[2], 32'h0000_1236);
    chk_eq("R3", "data2", wd[2], 8'h0F);
    chk_eq("R3", "first strobe position", wp[0], 10);
  endtask

  task automatic t_rec24_crlf();
    clear_log();
    send_str("=02 abCDef 11 22");
    send_char(8'h0D);
    send_char(8'h0A);
    expect_counts("R6", 2, 1, 0);
    chk_eq("R1", "24-bit addr0", wa[0], 32'h00AB_CDEF);
    chk_eq("R1", "24-bit addr1", wa[1], 32'h00AB_CDF0);
    chk_eq("R9", "done on CR only", wp[0] >= 0 ? ndone : 0, 1);
  endtask

  task automatic t_rec32_wrap();
    clear_log();
    send_str("+02 FFFFFFFF 5A a5\n");
    expect_counts("R1", 2, 1, 0);
    chk_eq("R1", "32-bit addr0", wa[0], 32'hFFFF_FFFF);
    chk_eq("R3", "wrapped addr1", wa[1], 32'h0000_0000);
    chk_eq("R4", "data1", wd[1], 8'hA5);
  endtask

  task automatic t_zero_count();
    clear_log();
    send_str("-00 0010\n");
    expect_counts("R6", 0, 1, 0);
  endtask

  task automatic t_short();
    clear_log();
    send_str("-03 0000 11 22\n");
    expect_counts("R7", 2, 0, 1);
    clear_log();
    send_str("-01 0000 1\n");
    expect_counts("R7", 0, 0, 1);
    clear_log();
    send_str("=01 0000\n");
    expect_counts("R7", 0, 0, 1);
  endtask

  task automatic t_extra();
    clear_log();
    send_str("-01 0100 33 44\n");
    expect_counts("R8", 1, 0, 1);
    chk_eq("R8", "kept byte", wd[0], 8'h33);
  endtask

  task automatic t_bad_then_good();
    clear_log();
    send_str("-02 00G0 11 22\n");
    expect_counts("R5", 0, 0, 1);
    clear_log();
    send_str("-01 0200 77\n");
    expect_counts("R5", 1, 1, 0);
    chk_eq("R5", "recovered addr", wa[0], 32'h0000_0200);
    chk_eq("R5", "recovered data", wd[0], 8'h77);
  endtask

  task automatic t_space_in_token();
    clear_log();
    send_str("-01 00 00 12\n");
    expect_counts("R2", 0, 0, 1);
  endtask

  task automatic t_blank();
    clear_log();
    send_str("\n");
    send_char(8'h0D);
    send_str("\n   \n\n");
    expect_counts("R9", 0, 0, 0);
  endtask

  task automatic t_reset_mid();
    clear_log();
    send_str("-02 0300 1");
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk_eq("R10", "pulses during reset", {29'b0, wr_en, rec_done, err}, 32'h0);
    rst = 1'b0;
    send_str("-01 0400 99\n");
    expect_counts("R10", 1, 1, 0);
    chk_eq("R10", "addr after reset", wa[0], 32'h0000_0400);
    chk_eq("R10", "data after reset", wd[0], 8'h99);
  endtask

  task automatic t_gaps();
    string s;
    clear_log();
    s = "-02 0500 C3 3C\n";
    for (int i = 0; i < s.len(); i++) begin
      send_char(s[i]);
      idle(2);
    end
    expect_counts("R11", 2, 1, 0);
    chk_eq("R11", "pulses in idle cycles", idle_hits, 0);
    chk_eq("R11", "addr1", wa[1], 32'h0000_0501);
    chk_eq("R11", "data1", wd[1], 8'h3C);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset_state();
    rst = 1'b0;
    @(negedge clk);
    t_rec16();
    t_rec24_crlf();
    t_rec32_wrap();
    t_zero_count();
    t_short();
    t_extra();
    t_bad_then_good();
    t_space_in_token();
    t_blank();
    t_reset_mid();
    t_gaps();
    idle(3);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule